// File: doc/BRIEF.md
# Cartridge Expansion Control Register Unit

This unit sits on the CPU write bus of a cartridge controller. It decodes writes in the 0x5000–0x5FFF window and holds the resulting control state. That state covers several functions:

- a two-key guard that allows stores into program-space RAM;
- an 8×8 unsigned multiplier whose factors are registers;
- the scanline interrupt target and its enable;
- the split-screen parameters;
- the upper bits applied to character bank numbers;
- a 1 KiB expansion RAM, whose writes are gated by an extended mode and by the current picture-processor state.

A second, independent address port reads back the registers, the multiplier product and the expansion RAM. It uses the same address decode as the write side.

Each write takes effect at the clock edge on which `wr_en` is high. All registered outputs show the new value from the following cycle. The read port is combinational from `rd_addr`.

Top module: `cart_xctl`

## Requirements
- R1: A write to an address below 0x5000, or to an address in the window that is not decoded, changes no output and no readable state.
- R2: Key registers at 0x5102 and 0x5103 keep only data bits 1:0, and each reads back as that value zero-extended. `prgram_wr_ok` is high exactly when the 0x5102 key holds 2 and the 0x5103 key holds 1.
- R3: Writes to 0x5205 and 0x5206 set the two 8-bit factors. In the cycle after either write, `mul_product` equals their unsigned 16-bit product. Reads of 0x5205 and 0x5206 return its low and high byte.
- R4: 0x5203 holds the 8-bit interrupt target scanline. It drives `irq_line` and reads back unchanged.
- R5: In a write to 0x5204, data bit 7 becomes `irq_enable`. When bit 7 is clear, `irq_pend_clr` is high for exactly the one cycle after the write. A read of 0x5204 returns `{irq_enable, 7'b0}`.
- R6: A write to 0x5200 sets `split_en` from bit 7, `split_side` from bit 6 and `split_tile` from bits 4:0. A read returns `{split_en, split_side, 1'b0, split_tile}`.
- R7: A value written to 0x5201 is stored as is below 240 and reduced by 16 at 240 or above, so `split_scroll` never reaches 240.
- R8: 0x5130 keeps data bits 1:0 as `chr_hi`. A write of d to 0x5120+i (i = 0..11) stores the 10-bit bank number `{chr_hi, d}`. A read of 0x5120+i returns the low byte on `rd_data` and the upper two bits on `rd_bank_hi`, which is 0 for every other address.
- R9: `ext_mode` is data bits 1:0 of the last write to 0x5104. A write to 0x5C00–0x5FFF addresses expansion RAM byte `addr[9:0]`, and a read of that range returns the byte.
- R10: In extended modes 0 and 1, an expansion RAM write stores the data only when `ppu_render_on` is high, `ppu_vblank` is low and `ppu_visible_line` is high. Otherwise it stores zero.
- R11: In extended mode 2 an expansion RAM write always stores the data. In mode 3 it leaves the RAM unchanged.
- R12: After reset every register is zero: all outputs low, `ext_mode` 0, and reads of register addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | CPU write strobe for this cycle |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rd_addr | input | 16 | Read port address |
| ppu_render_on | input | 1 | Picture rendering enabled |
| ppu_vblank | input | 1 | Picture processor in vertical blank |
| ppu_visible_line | input | 1 | Current line is a visible line |
| rd_data | output | 8 | Read port data |
| rd_bank_hi | output | 2 | Upper bits of a character bank number on read |
| prgram_wr_ok | output | 1 | Program-space RAM write permitted |
| mul_product | output | 16 | Product of the two factors |
| irq_line | output | 8 | Interrupt target scanline |
| irq_enable | output | 1 | Scanline interrupt enabled |
| irq_pend_clr | output | 1 | One-cycle pulse clearing a pending interrupt |
| split_en | output | 1 | Split screen enabled |
| split_side | output | 1 | Split side select |
| split_tile | output | 5 | Split start tile |
| split_scroll | output | 8 | Split vertical scroll |
| chr_hi | output | 2 | Upper bits for character bank numbers |
| ext_mode | output | 2 | Expansion RAM mode |

## Verification
The bench builds the unit with its defaults: twelve character bank registers and a 10-bit expansion RAM index. With these values every bank slot, the unused slots 0x512C–0x512F and both ends of the RAM index range can be reached by directed writes, and long random runs revisit them often. The 8-bit factors let the full-scale product 255×255 and the scroll wrap at 240 be hit directly. The random traffic crosses the four extended modes with every combination of the three picture-processor flags.

// File: rtl/xctl_pkg.sv
package xctl_pkg;

  localparam int XDW = 8;
  localparam logic [XDW-1:0] SCROLL_WRAP = 8'd240;
  localparam logic [XDW-1:0] SCROLL_ADJ  = 8'd16;
  localparam logic [1:0] KEY_A_VAL = 2'd2;
  localparam logic [1:0] KEY_B_VAL = 2'd1;

  localparam logic [15:0] A_KEY_A   = 16'h5102;
  localparam logic [15:0] A_KEY_B   = 16'h5103;
  localparam logic [15:0] A_XMODE   = 16'h5104;
  localparam logic [15:0] A_CHRHI   = 16'h5130;
  localparam logic [15:0] A_SPLIT   = 16'h5200;
  localparam logic [15:0] A_SCROLL  = 16'h5201;
  localparam logic [15:0] A_IRQLINE = 16'h5203;
  localparam logic [15:0] A_IRQCTL  = 16'h5204;
  localparam logic [15:0] A_FAC_A   = 16'h5205;
  localparam logic [15:0] A_FAC_B   = 16'h5206;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_KEY_A, SEL_KEY_B, SEL_XMODE, SEL_CHRB, SEL_CHRHI,
    SEL_SPLIT, SEL_SCROLL, SEL_IRQLINE, SEL_IRQCTL, SEL_FAC_A, SEL_FAC_B,
    SEL_XRAM
  } xsel_e;

  typedef struct packed {
    logic [1:0]     key_a;
    logic [1:0]     key_b;
    logic [1:0]     xmode;
    logic [1:0]     chr_hi;
    logic [XDW-1:0] fac_a;
    logic [XDW-1:0] fac_b;
    logic [XDW-1:0] irq_line;
    logic [XDW-1:0] scroll;
    logic           irq_en;
    logic           irq_clr;
    logic           split_en;
    logic           split_side;
    logic [4:0]     split_tile;
  } xstate_t;

  function automatic xsel_e xdecode(input logic [15:0] a);
    xsel_e s;
    s = SEL_NONE;
    if (a[15:12] == 4'h5) begin
      if (a[11:10] == 2'b11) begin
        s = SEL_XRAM;
      end else begin
        unique case (a)
          A_KEY_A:   s = SEL_KEY_A;
          A_KEY_B:   s = SEL_KEY_B;
          A_XMODE:   s = SEL_XMODE;
          A_CHRHI:   s = SEL_CHRHI;
          A_SPLIT:   s = SEL_SPLIT;
          A_SCROLL:  s = SEL_SCROLL;
          A_IRQLINE: s = SEL_IRQLINE;
          A_IRQCTL:  s = SEL_IRQCTL;
          A_FAC_A:   s = SEL_FAC_A;
          A_FAC_B:   s = SEL_FAC_B;
          default:   s = (a[15:4] == 12'h512) ? SEL_CHRB : SEL_NONE;
        endcase
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/xctl_mul.sv
module xctl_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   fac_a,
  input  logic [W-1:0]   fac_b,
  output logic [2*W-1:0] prod
);

  logic [2*W-1:0] partial [W];

  for (genvar i = 0; i < W; i++) begin : g_pp
    assign partial[i] = fac_b[i] ? ({{W{1'b0}}, fac_a} << i) : '0;
  end

  always_comb begin
    prod = '0;
    for (int i = 0; i < W; i++) begin
      prod = prod + partial[i];
    end
  end

endmodule

// File: rtl/xctl_regs.sv
module xctl_regs
  import xctl_pkg::*;
#(
  parameter int NB = 12,
  localparam int IW = $clog2(NB)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  xsel_e                     sel,
  input  logic [IW-1:0]             idx,
  input  logic [XDW-1:0]            din,
  output xstate_t                   st_q,
  output logic [NB-1:0][XDW+1:0]    bank_q
);

  xstate_t st_d;

  always_comb begin
    st_d         = st_q;
    st_d.irq_clr = 1'b0;
    if (wr_en) begin
      unique case (sel)
        SEL_KEY_A:   st_d.key_a    = din[1:0];
        SEL_KEY_B:   st_d.key_b    = din[1:0];
        SEL_XMODE:   st_d.xmode    = din[1:0];
        SEL_CHRHI:   st_d.chr_hi   = din[1:0];
        SEL_FAC_A:   st_d.fac_a    = din;
        SEL_FAC_B:   st_d.fac_b    = din;
        SEL_IRQLINE: st_d.irq_line = din;
        SEL_SCROLL:  st_d.scroll   = (din >= SCROLL_WRAP) ? (din - SCROLL_ADJ) : din;
        SEL_IRQCTL: begin
          st_d.irq_en  = din[7];
          st_d.irq_clr = ~din[7];
        end
        SEL_SPLIT: begin
          st_d.split_en   = din[7];
          st_d.split_side = din[6];
          st_d.split_tile = din[4:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic           ce;
    logic [XDW+1:0] q;
    assign ce = wr_en && (sel == SEL_CHRB) && (idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (ce) begin
        q <= {st_q.chr_hi, din};
      end
    end
    assign bank_q[g] = q;
  end

endmodule

// File: rtl/xctl_xram.sv
module xctl_xram #(
  parameter int AW = 10,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          hit,
  input  logic [AW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    mode,
  input  logic          render_on,
  input  logic          vblank,
  input  logic          visible,
  input  logic [AW-1:0] ridx,
  output logic [DW-1:0] rdata,
  output logic          we
);

  logic [DW-1:0] mem [DEPTH];
  logic          live;
  logic [DW-1:0] wval;

  always_comb begin
    live = render_on && !vblank && visible;
    we   = hit && (mode != 2'd3);
    wval = (!mode[1] && !live) ? '0 : wdata;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem[widx] <= wval;
    end
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/cart_xctl.sv
module cart_xctl
  import xctl_pkg::*;
#(
  parameter int NB  = 12,
  parameter int XAW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [15:0] rd_addr,
  input  logic        ppu_render_on,
  input  logic        ppu_vblank,
  input  logic        ppu_visible_line,
  output logic [7:0]  rd_data,
  output logic [1:0]  rd_bank_hi,
  output logic        prgram_wr_ok,
  output logic [15:0] mul_product,
  output logic [7:0]  irq_line,
  output logic        irq_enable,
  output logic        irq_pend_clr,
  output logic        split_en,
  output logic        split_side,
  output logic [4:0]  split_tile,
  output logic [7:0]  split_scroll,
  output logic [1:0]  chr_hi,
  output logic [1:0]  ext_mode
);

  localparam int IW = $clog2(NB);

  logic [1:0]              rst_sync;
  logic                    rst_int_n;
  xsel_e                   wsel;
  xsel_e                   rsel;
  xstate_t                 st;
  logic [NB-1:0][XDW+1:0]  bank;
  logic [2*XDW-1:0]        prod;
  logic [XDW-1:0]          xq;
  logic                    xram_we_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  assign wsel = xdecode(wr_addr);
  assign rsel = xdecode(rd_addr);

  xctl_regs #(.NB(NB)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (wr_en),
    .sel    (wsel),
    .idx    (wr_addr[IW-1:0]),
    .din    (wr_data),
    .st_q   (st),
    .bank_q (bank)
  );

  xctl_mul #(.W(XDW)) u_mul (
    .fac_a (st.fac_a),
    .fac_b (st.fac_b),
    .prod  (prod)
  );

  xctl_xram #(.AW(XAW), .DW(XDW)) u_xram (
    .clk       (clk),
    .hit       (wr_en && (wsel == SEL_XRAM)),
    .widx      (wr_addr[XAW-1:0]),
    .wdata     (wr_data),
    .mode      (st.xmode),
    .render_on (ppu_render_on),
    .vblank    (ppu_vblank),
    .visible   (ppu_visible_line),
    .ridx      (rd_addr[XAW-1:0]),
    .rdata     (xq),
    .we        (xram_we_w)
  );

  always_comb begin
    rd_data    = '0;
    rd_bank_hi = '0;
    unique case (rsel)
      SEL_KEY_A:   rd_data = {6'b0, st.key_a};
      SEL_KEY_B:   rd_data = {6'b0, st.key_b};
      SEL_XMODE:   rd_data = {6'b0, st.xmode};
      SEL_CHRHI:   rd_data = {6'b0, st.chr_hi};
      SEL_SPLIT:   rd_data = {st.split_en, st.split_side, 1'b0, st.split_tile};
      SEL_SCROLL:  rd_data = st.scroll;
      SEL_IRQLINE: rd_data = st.irq_line;
      SEL_IRQCTL:  rd_data = {st.irq_en, 7'b0};
      SEL_FAC_A:   rd_data = prod[XDW-1:0];
      SEL_FAC_B:   rd_data = prod[2*XDW-1:XDW];
      SEL_XRAM:    rd_data = xq;
      SEL_CHRB: begin
        if (int'(rd_addr[IW-1:0]) < NB) begin
          rd_data    = bank[rd_addr[IW-1:0]][XDW-1:0];
          rd_bank_hi = bank[rd_addr[IW-1:0]][XDW+1:XDW];
        end
      end
      default: ;
    endcase
  end

  assign prgram_wr_ok = (st.key_a == KEY_A_VAL) && (st.key_b == KEY_B_VAL);
  assign mul_product  = prod;
  assign irq_line     = st.irq_line;
  assign irq_enable   = st.irq_en;
  assign irq_pend_clr = st.irq_clr;
  assign split_en     = st.split_en;
  assign split_side   = st.split_side;
  assign split_tile   = st.split_tile;
  assign split_scroll = st.scroll;
  assign chr_hi       = st.chr_hi;
  assign ext_mode     = st.xmode;

endmodule

// File: rtl/xctl_chk.sv
module xctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_addr,
  input logic        wr_b7,
  input logic        prgram_wr_ok,
  input logic        irq_enable,
  input logic        irq_pend_clr,
  input logic [7:0]  split_scroll,
  input logic [1:0]  chr_hi,
  input logic [1:0]  ext_mode,
  input logic        xram_we
);

  logic low_wr;
  logic xram_wr;
  assign low_wr  = wr_en && (wr_addr < 16'h5000);
  assign xram_wr = wr_en && (wr_addr[15:10] == 6'b010111);

  p_low_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    low_wr |=> ($stable(prgram_wr_ok) && $stable(irq_enable) && $stable(split_scroll)
                && $stable(chr_hi) && $stable(ext_mode) && !irq_pend_clr));

  p_key_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prgram_wr_ok) |-> $past(wr_en && (wr_addr[15:1] == 15'h2881)));

  p_clear_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend_clr |-> (!irq_enable && $past(wr_en && (wr_addr == 16'h5204) && !wr_b7)));

  p_scroll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    split_scroll < 8'd240);

  p_hi_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chr_hi) |-> $past(wr_en && (wr_addr == 16'h5130)));

  p_mode3_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xram_wr && (ext_mode == 2'd3)) |-> !xram_we);

  p_mode2_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xram_wr && (ext_mode == 2'd2)) |-> xram_we);

endmodule

bind cart_xctl xctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_b7        (wr_data[7]),
  .prgram_wr_ok (prgram_wr_ok),
  .irq_enable   (irq_enable),
  .irq_pend_clr (irq_pend_clr),
  .split_scroll (split_scroll),
  .chr_hi       (chr_hi),
  .ext_mode     (ext_mode),
  .xram_we      (xram_we_w)
);

// File: tb/cart_xctl_test.sv
module cart_xctl_test;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic [15:0] rd_addr;
  logic        ppu_render_on, ppu_vblank, ppu_visible_line;
  logic [7:0]  rd_data;
  logic [1:0]  rd_bank_hi;
  logic        prgram_wr_ok;
  logic [15:0] mul_product;
  logic [7:0]  irq_line;
  logic        irq_enable, irq_pend_clr, split_en, split_side;
  logic [4:0]  split_tile;
  logic [7:0]  split_scroll;
  logic [1:0]  chr_hi, ext_mode;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 0;
  bit done   = 0;

  // behavioural reference state
  int m_ka, m_kb, m_xm, m_hi, m_fa, m_fb, m_line, m_scr, m_ien, m_clr;
  int m_sen, m_sside, m_stile;
  int m_bank [12];
  int m_mem  [1024];
  bit m_wr   [1024];

  always #(PERIOD/2) clk = ~clk;

  cart_xctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .ppu_render_on(ppu_render_on), .ppu_vblank(ppu_vblank),
    .ppu_visible_line(ppu_visible_line), .rd_data(rd_data), .rd_bank_hi(rd_bank_hi),
    .prgram_wr_ok(prgram_wr_ok), .mul_product(mul_product), .irq_line(irq_line),
    .irq_enable(irq_enable), .irq_pend_clr(irq_pend_clr), .split_en(split_en),
    .split_side(split_side), .split_tile(split_tile), .split_scroll(split_scroll),
    .chr_hi(chr_hi), .ext_mode(ext_mode)
  );

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ka = 0; m_kb = 0; m_xm = 0; m_hi = 0; m_fa = 0; m_fb = 0; m_line = 0;
    m_scr = 0; m_ien = 0; m_clr = 0; m_sen = 0; m_sside = 0; m_stile = 0;
    for (int i = 0; i < 12; i++) m_bank[i] = 0;
    for (int i = 0; i < 1024; i++) m_wr[i] = 0;
  endtask

  function automatic int exp_rd(int a);
    int p;
    p = m_fa * m_fb;
    if (a >= 'h5C00 && a <= 'h5FFF) return m_wr[a & 1023] ? m_mem[a & 1023] : -1;
    if (a >= 'h5120 && a <= 'h512B) return m_bank[a - 'h5120] & 255;
    case (a)
      'h5102: return m_ka;
      'h5103: return m_kb;
      'h5104: return m_xm;
      'h5130: return m_hi;
      'h5200: return m_sen * 128 + m_sside * 64 + m_stile;
      'h5201: return m_scr;
      'h5203: return m_line;
      'h5204: return m_ien * 128;
      'h5205: return p & 255;
      'h5206: return p / 256;
      default: return 0;
    endcase
  endfunction

  // cycle reference model, compared on every clock
  always @(posedge clk) begin
    int a, d, e;
    bit live;
    a = int'(wr_addr); d = int'(wr_data);
    live = ppu_render_on && !ppu_vblank && ppu_visible_line;
    m_clr = 0;
    if (cmp_on && wr_en) begin
      if (a >= 'h5C00 && a <= 'h5FFF) begin
        if (m_xm == 2) begin m_mem[a & 1023] = d; m_wr[a & 1023] = 1; end
        else if (m_xm < 2) begin m_mem[a & 1023] = live ? d : 0; m_wr[a & 1023] = 1; end
      end else if (a >= 'h5120 && a <= 'h512B) begin
        m_bank[a - 'h5120] = m_hi * 256 + d;
      end else begin
        case (a)
          'h5102: m_ka = d % 4;
          'h5103: m_kb = d % 4;
          'h5104: m_xm = d % 4;
          'h5130: m_hi = d % 4;
          'h5200: begin m_sen = d / 128; m_sside = (d / 64) % 2; m_stile = d % 32; end
          'h5201: m_scr = (d >= 240) ? d - 16 : d;
          'h5203: m_line = d;
          'h5204: begin m_ien = d / 128; m_clr = (d < 128) ? 1 : 0; end
          'h5205: m_fa = d;
          'h5206: m_fb = d;
          default: ;
        endcase
      end
    end
    #2;
    if (cmp_on) begin
      cmp("R2 prgram_wr_ok", int'(prgram_wr_ok), (m_ka == 2 && m_kb == 1) ? 1 : 0);
      cmp("R3 mul_product", int'(mul_product), m_fa * m_fb);
      cmp("R4 irq_line", int'(irq_line), m_line);
      cmp("R5 irq_enable", int'(irq_enable), m_ien);
      cmp("R5 irq_pend_clr", int'(irq_pend_clr), m_clr);
      cmp("R6 split fields", int'({split_en, split_side, split_tile}),
          m_sen * 64 + m_sside * 32 + m_stile);
      cmp("R7 split_scroll", int'(split_scroll), m_scr);
      cmp("R8 chr_hi", int'(chr_hi), m_hi);
      cmp("R9 ext_mode", int'(ext_mode), m_xm);
      e = exp_rd(int'(rd_addr));
      if (e >= 0) cmp("R1 R9 rd_data", int'(rd_data), e);
      cmp("R8 rd_bank_hi", int'(rd_bank_hi),
          (rd_addr >= 16'h5120 && rd_addr <= 16'h512B) ? m_bank[int'(rd_addr) - 'h5120] / 256 : 0);
    end
  end

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdc(logic [15:0] a, int exp, string tag);
    rd_addr = a;
    #1;
    cmp(tag, int'(rd_data), exp);
  endtask

  task automatic flags(bit r, bit vb, bit vis);
    ppu_render_on = r; ppu_vblank = vb; ppu_visible_line = vis;
  endtask

  function automatic logic [15:0] pick();
    int r;
    r = $urandom_range(0, 19);
    case (r)
      0: return 16'h5102;
      1: return 16'h5103;
      2: return 16'h5104;
      3: return 16'h5130;
      4: return 16'h5200;
      5: return 16'h5201;
      6: return 16'h5203;
      7: return 16'h5204;
      8: return 16'h5205;
      9: return 16'h5206;
      10, 11: return 16'h5120 + 16'($urandom_range(0, 15));
      12, 13: return 16'h5C00 + 16'($urandom_range(0, 31));
      14: return 16'h5FE0 + 16'($urandom_range(0, 31));
      15: return 16'h4000 + 16'($urandom_range(0, 4095));
      16: return 16'h5000 + 16'($urandom_range(0, 255));
      default: return 16'($urandom_range(0, 16'h4FFF));
    endcase
  endfunction

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R12 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    flags(0, 0, 0);
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state
    cmp("R12 prgram_wr_ok", int'(prgram_wr_ok), 0);
    cmp("R12 mul_product", int'(mul_product), 0);
    cmp("R12 irq outputs", int'({irq_enable, irq_pend_clr, irq_line}), 0);
    cmp("R12 split outputs", int'({split_en, split_side, split_tile, split_scroll}), 0);
    cmp("R12 chr_hi ext_mode", int'({chr_hi, ext_mode}), 0);
    rdc(16'h5204, 0, "R12 read irq ctl");
    cmp_on = 1;

    // R2: two-key guard
    wr(16'h5102, 8'h02);
    cmp("R2 one key only", int'(prgram_wr_ok), 0);
    wr(16'h5103, 8'hFD);
    cmp("R2 both keys, upper bits dropped", int'(prgram_wr_ok), 1);
    rdc(16'h5103, 1, "R2 key read");
    // R1: low address alias of key register
    wr(16'h4103, 8'h00);
    cmp("R1 low write ignored", int'(prgram_wr_ok), 1);
    wr(16'h5103, 8'h03);
    cmp("R2 wrong key", int'(prgram_wr_ok), 0);

    // R3: multiplier
    wr(16'h5205, 8'hFF);
    wr(16'h5206, 8'hFF);
    cmp("R3 full scale", int'(mul_product), 65025);
    rdc(16'h5205, 8'h01, "R3 low byte");
    rdc(16'h5206, 8'hFE, "R3 high byte");
    wr(16'h4205, 8'h03);
    cmp("R1 product unchanged", int'(mul_product), 65025);
    wr(16'h5206, 8'h00);
    cmp("R3 zero factor", int'(mul_product), 0);

    // R4, R5
    wr(16'h5203, 8'hA7);
    cmp("R4 irq_line", int'(irq_line), 8'hA7);
    wr(16'h5204, 8'h80);
    cmp("R5 enable", int'({irq_enable, irq_pend_clr}), 2);
    wr(16'h5204, 8'h7F);
    cmp("R5 disable pulse", int'({irq_enable, irq_pend_clr}), 1);
    @(negedge clk);
    cmp("R5 pulse one cycle", int'(irq_pend_clr), 0);

    // R6, R7
    wr(16'h5200, 8'hFF);
    rdc(16'h5200, 8'hDF, "R6 split read");
    cmp("R6 split tile", int'(split_tile), 31);
    wr(16'h5201, 8'd240);
    cmp("R7 wrap at 240", int'(split_scroll), 224);
    wr(16'h5201, 8'd239);
    cmp("R7 below limit", int'(split_scroll), 239);
    wr(16'h5201, 8'd255);
    cmp("R7 top value", int'(split_scroll), 239);

    // R8: high bits latched into later bank writes
    wr(16'h5123, 8'h45);
    wr(16'h5130, 8'hFF);
    wr(16'h512B, 8'h9C);
    rdc(16'h5123, 8'h45, "R8 earlier bank low");
    cmp("R8 earlier bank hi", int'(rd_bank_hi), 0);
    rdc(16'h512B, 8'h9C, "R8 last bank low");
    cmp("R8 last bank hi", int'(rd_bank_hi), 3);
    wr(16'h512C, 8'h11);
    rdc(16'h512C, 0, "R1 undecoded bank slot");

    // R9..R11: expansion RAM
    wr(16'h5104, 8'hFC);
    cmp("R9 mode 0", int'(ext_mode), 0);
    flags(1, 0, 1);
    wr(16'h5C05, 8'hAA);
    rdc(16'h5C05, 8'hAA, "R10 live store");
    flags(1, 1, 1);
    wr(16'h5C06, 8'h55);
    rdc(16'h5C06, 0, "R10 vblank zero");
    wr(16'h5104, 8'h01);
    flags(0, 0, 1);
    wr(16'h5C05, 8'h66);
    rdc(16'h5C05, 0, "R10 mode 1 render off zero");
    wr(16'h5104, 8'h06);
    cmp("R9 mode low bits", int'(ext_mode), 2);
    wr(16'h5FFF, 8'h77);
    rdc(16'h5FFF, 8'h77, "R11 mode 2 store");
    rdc(16'h5BFF, 0, "R9 below ram window");
    wr(16'h5104, 8'h03);
    wr(16'h5FFF, 8'h11);
    rdc(16'h5FFF, 8'h77, "R11 mode 3 ignored");

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      wr_en = ($urandom_range(0, 1) == 1);
      wr_addr = pick();
      wr_data = 8'($urandom_range(0, 255));
      rd_addr = pick();
      flags(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule